// File: doc/BRIEF.md
# Random Source Health Monitor

This block sits beside a hardware random number generator and watches its raw entropy. It runs in the system clock domain. It receives the raw entropy bits, each marked by a valid strobe, and a one-cycle pulse for every edge of the entropy clock. That edge pulse is already synchronized to the system clock. From these inputs the block keeps the live health conditions and the sticky interrupt flags that a driver polls or takes an interrupt on.

The block raises a seed fault in two cases: the raw stream sticks at one value for too long, or it toggles on every bit for too long. It raises a clock fault when the entropy clock runs slower than a fixed fraction of the system clock. Each fault has a live status bit that follows the present condition. Each fault also has a sticky flag that software clears by writing 0 to it. A data-ready bit tracks whether a freshly generated random word is waiting to be read. The interrupt request is the OR of the sticky flags, qualified by an enable input.

Top module: `rng_health_mon`

## Requirements
- R1: When valid raw bits of one value arrive more than RUN_LIMIT (default 64) times in a row, the seed status (bit 2) is 1 in the cycle after the offending bit. Cycles with `raw_vld` low do not advance or break a run.
- R2: When more than ALT_LIMIT (default 32) consecutive valid bits each differ from the bit before them, the seed status is 1 in the cycle after the offending bit. At the default, that is 33 transitions, or 34 alternating bits.
- R3: The seed status returns to 0 in the cycle after a valid bit that leaves both the run length and the transition count at or below their limits.
- R4: The clock status (bit 1) becomes 1 after CLK_RATIO (default 16) consecutive system cycles with no `ent_clk_edge`. An edge arriving at least once every CLK_RATIO cycles never raises it.
- R5: The clock status clears in the cycle after an edge that arrives within CLK_RATIO cycles of the previous edge. An edge that arrives late leaves the status at 1.
- R6: Data-ready (bit 0) sets the cycle after `new_word` and clears the cycle after `data_rd`. When both arrive in the same cycle, the bit is set.
- R7: The seed flag (bit 6) and the clock flag (bit 5) become 1 the cycle after their live status is 1. A status write with 0 in the flag's bit position clears the flag. Writing 1 leaves the flag unchanged.
- R8: A write of 0 to a flag in a cycle where its live status is 1 leaves the flag at 1.
- R9: Bits 31:7 and 4:3 of `stat_word` always read 0.
- R10: `irq` is 1 exactly when `irq_en` is 1 and at least one of the two flags is 1.
- R11: After a synchronous reset, `stat_word` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_bit | input | 1 | Raw entropy bit |
| raw_vld | input | 1 | `raw_bit` is valid in this cycle |
| ent_clk_edge | input | 1 | One-cycle pulse per entropy-clock edge, already synchronized |
| new_word | input | 1 | Pulse: a new random word was generated |
| data_rd | input | 1 | Pulse: the random data word was read |
| stat_wr_en | input | 1 | Write strobe for the status word |
| stat_wdata | input | 32 | Write data; bits 5 and 6 are the flag clear controls |
| irq_en | input | 1 | Interrupt enable |
| stat_word | output | 32 | Status word: 0 ready, 1 clock live, 2 seed live, 5 clock flag, 6 seed flag |
| irq | output | 1 | Interrupt request |

## Verification
Every internal counter in this block feeds a live status bit directly. A run or transition counter that is off by one therefore shows as bit 2 moving one valid bit too early or too late. A gap counter that is off by one shifts bit 1 by one system cycle. A corrupt flag term shows in bit 5 or 6 one cycle after the live bit, and in `irq` in the same cycle as the flag. The bench compares every status bit and `irq` against a behavioural model after every clock edge. Any divergence is therefore reported within one cycle of its first appearance at the ports.

// File: rtl/rng_health_pkg.sv
package rng_health_pkg;

    localparam int unsigned STAT_W    = 32;
    localparam int unsigned POS_READY = 0;
    localparam int unsigned POS_CLIVE = 1;
    localparam int unsigned POS_SLIVE = 2;
    localparam int unsigned POS_CFLAG = 5;
    localparam int unsigned POS_SFLAG = 6;

    // Relation of a new raw bit to the one before it
    typedef enum logic [1:0] {
        REL_FIRST  = 2'd0,
        REL_REPEAT = 2'd1,
        REL_TOGGLE = 2'd2
    } bit_rel_t;

    typedef struct packed {
        logic seed_flag;
        logic clk_flag;
        logic seed_live;
        logic clk_live;
        logic ready;
    } health_stat_t;

    function automatic logic [STAT_W-1:0] pack_status(input health_stat_t s);
        logic [STAT_W-1:0] w;
        w            = '0;
        w[POS_READY] = s.ready;
        w[POS_CLIVE] = s.clk_live;
        w[POS_SLIVE] = s.seed_live;
        w[POS_CFLAG] = s.clk_flag;
        w[POS_SFLAG] = s.seed_flag;
        return w;
    endfunction

endpackage

// File: rtl/seed_pattern_chk.sv
module seed_pattern_chk
    import rng_health_pkg::*;
#(
    parameter int unsigned RUN_LIMIT = 64,
    parameter int unsigned ALT_LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_bit,
    input  logic raw_vld,
    output logic seed_err
);
    localparam int unsigned RUN_MAX = RUN_LIMIT + 1;
    localparam int unsigned ALT_MAX = ALT_LIMIT + 1;
    localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);
    localparam int unsigned ALT_W   = $clog2(ALT_MAX + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);
    localparam logic [ALT_W-1:0] ALT_TOP = ALT_W'(ALT_MAX);
    localparam logic [RUN_W-1:0] RUN_TH  = RUN_W'(RUN_LIMIT);
    localparam logic [ALT_W-1:0] ALT_TH  = ALT_W'(ALT_LIMIT);

    logic             have_prev;
    logic             prev_bit;
    logic [RUN_W-1:0] run_q;
    logic [ALT_W-1:0] alt_q;
    bit_rel_t         rel;

    always_comb begin
        if (!have_prev)            rel = REL_FIRST;
        else if (raw_bit == prev_bit) rel = REL_REPEAT;
        else                       rel = REL_TOGGLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b0;
            run_q     <= '0;
            alt_q     <= '0;
        end else if (raw_vld) begin
            have_prev <= 1'b1;
            prev_bit  <= raw_bit;
            case (rel)
                REL_REPEAT: begin
                    run_q <= (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
                    alt_q <= '0;
                end
                REL_TOGGLE: begin
                    run_q <= RUN_W'(1);
                    alt_q <= (alt_q == ALT_TOP) ? alt_q : alt_q + 1'b1;
                end
                default: begin
                    run_q <= RUN_W'(1);
                    alt_q <= '0;
                end
            endcase
        end
    end

    assign seed_err = (run_q > RUN_TH) || (alt_q > ALT_TH);

endmodule

// File: rtl/clk_rate_chk.sv
module clk_rate_chk #(
    parameter int unsigned CLK_RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ent_edge,
    output logic clk_err
);
    localparam int unsigned GAP_W = $clog2(CLK_RATIO + 1);
    localparam logic [GAP_W-1:0] GAP_LIM  = GAP_W'(CLK_RATIO);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CLK_RATIO - 1);

    logic [GAP_W-1:0] gap_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            err_q <= 1'b0;
        end else if (ent_edge) begin
            gap_q <= '0;
            if (gap_q < GAP_LIM) err_q <= 1'b0;
        end else begin
            if (gap_q != GAP_LIM)  gap_q <= gap_q + 1'b1;
            if (gap_q == GAP_LAST) err_q <= 1'b1;
        end
    end

    assign clk_err = err_q;

endmodule

// File: rtl/rng_status_reg.sv
module rng_status_reg
    import rng_health_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_live,
    input  logic              clk_live,
    input  logic              new_word,
    input  logic              data_rd,
    input  logic              wr_en,
    input  logic              wr_clr_seed_n,
    input  logic              wr_clr_clk_n,
    input  logic              irq_en,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq
);
    logic         ready_q;
    logic         sflag_q;
    logic         cflag_q;
    logic         clr_seed;
    logic         clr_clk;
    health_stat_t fields;

    assign clr_seed = wr_en && !wr_clr_seed_n;
    assign clr_clk  = wr_en && !wr_clr_clk_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            sflag_q <= 1'b0;
            cflag_q <= 1'b0;
        end else begin
            ready_q <= new_word  || (ready_q && !data_rd);
            sflag_q <= seed_live || (sflag_q && !clr_seed);
            cflag_q <= clk_live  || (cflag_q && !clr_clk);
        end
    end

    always_comb begin
        fields.ready     = ready_q;
        fields.clk_live  = clk_live;
        fields.seed_live = seed_live;
        fields.clk_flag  = cflag_q;
        fields.seed_flag = sflag_q;
    end

    assign stat_word = pack_status(fields);
    assign irq       = irq_en && (sflag_q || cflag_q);

endmodule

// File: rtl/rng_health_mon.sv
module rng_health_mon
    import rng_health_pkg::*;
#(
    parameter int unsigned RUN_LIMIT = 64,
    parameter int unsigned ALT_LIMIT = 32,
    parameter int unsigned CLK_RATIO = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        raw_bit,
    input  logic        raw_vld,
    input  logic        ent_clk_edge,
    input  logic        new_word,
    input  logic        data_rd,
    input  logic        stat_wr_en,
    input  logic [31:0] stat_wdata,
    input  logic        irq_en,
    output logic [31:0] stat_word,
    output logic        irq
);
    logic seed_live;
    logic clk_live;
    logic unused_wbits;

    assign unused_wbits = ^{stat_wdata[31:7], stat_wdata[4:0]};

    seed_pattern_chk #(
        .RUN_LIMIT (RUN_LIMIT),
        .ALT_LIMIT (ALT_LIMIT)
    ) i_seed (
        .clk      (clk),
        .rst      (rst),
        .raw_bit  (raw_bit),
        .raw_vld  (raw_vld),
        .seed_err (seed_live)
    );

    clk_rate_chk #(
        .CLK_RATIO (CLK_RATIO)
    ) i_rate (
        .clk      (clk),
        .rst      (rst),
        .ent_edge (ent_clk_edge),
        .clk_err  (clk_live)
    );

    rng_status_reg i_stat (
        .clk           (clk),
        .rst           (rst),
        .seed_live     (seed_live),
        .clk_live      (clk_live),
        .new_word      (new_word),
        .data_rd       (data_rd),
        .wr_en         (stat_wr_en),
        .wr_clr_seed_n (stat_wdata[POS_SFLAG]),
        .wr_clr_clk_n  (stat_wdata[POS_CFLAG]),
        .irq_en        (irq_en),
        .stat_word     (stat_word),
        .irq           (irq)
    );

endmodule

// File: rtl/rng_health_mon_chk.sv
module rng_health_mon_chk (
    input logic        clk,
    input logic        rst,
    input logic        raw_vld,
    input logic        ent_clk_edge,
    input logic        new_word,
    input logic        data_rd,
    input logic        stat_wr_en,
    input logic [31:0] stat_wdata,
    input logic        irq_en,
    input logic [31:0] stat_word,
    input logic        irq
);
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (stat_word & 32'hFFFF_FF98) == 32'h0);

    a_r1_seed_rise_needs_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_word[2]) |-> $past(raw_vld));

    a_r4_clk_rise_needs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_word[1]) |-> !$past(ent_clk_edge));

    a_r7_seed_flag_follows: assert property (@(posedge clk) disable iff (rst)
        stat_word[2] |=> stat_word[6]);

    a_r7_clk_flag_follows: assert property (@(posedge clk) disable iff (rst)
        stat_word[1] |=> stat_word[5]);

    a_r8_seed_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (stat_word[6] && !(stat_wr_en && !stat_wdata[6])) |=> stat_word[6]);

    a_r8_clk_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (stat_word[5] && !(stat_wr_en && !stat_wdata[5])) |=> stat_word[5]);

    a_r6_ready_sets: assert property (@(posedge clk) disable iff (rst)
        new_word |=> stat_word[0]);

    a_r6_ready_clears: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !new_word) |=> !stat_word[0]);

    a_r10_irq_gate: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

bind rng_health_mon rng_health_mon_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .raw_vld      (raw_vld),
    .ent_clk_edge (ent_clk_edge),
    .new_word     (new_word),
    .data_rd      (data_rd),
    .stat_wr_en   (stat_wr_en),
    .stat_wdata   (stat_wdata),
    .irq_en       (irq_en),
    .stat_word    (stat_word),
    .irq          (irq)
);

// File: tb/test_rng_health_mon.sv
`timescale 1ns/1ps
module test_rng_health_mon;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raw_bit = 1'b0;
    logic        raw_vld = 1'b0;
    logic        ent_clk_edge = 1'b0;
    logic        new_word = 1'b0;
    logic        data_rd = 1'b0;
    logic        stat_wr_en = 1'b0;
    logic [31:0] stat_wdata = 32'h0;
    logic        irq_en = 1'b0;
    logic [31:0] stat_word;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // entropy-clock edge generator control (0 = no edges)
    int ep  = 8;
    int ecc = 0;

    // reference model state
    int m_run = 0, m_alt = 0, m_gap = 0;
    bit m_have = 0, m_last = 0;
    bit m_clive = 0, m_rdy = 0, m_sflag = 0, m_cflag = 0;

    always #2 clk = ~clk;

    rng_health_mon i_rng_health_mon (
        .clk(clk), .rst(rst), .raw_bit(raw_bit), .raw_vld(raw_vld),
        .ent_clk_edge(ent_clk_edge), .new_word(new_word), .data_rd(data_rd),
        .stat_wr_en(stat_wr_en), .stat_wdata(stat_wdata), .irq_en(irq_en),
        .stat_word(stat_word), .irq(irq)
    );

    function automatic bit m_slive();
        return (m_run > 64) || (m_alt > 32);
    endfunction

    always @(posedge clk) begin
        bit old_s, old_c;
        old_s = m_slive();
        old_c = m_clive;
        if (rst) begin
            m_run = 0; m_alt = 0; m_gap = 0; m_have = 0; m_last = 0;
            m_clive = 0; m_rdy = 0; m_sflag = 0; m_cflag = 0;
        end else begin
            if (raw_vld) begin
                if (!m_have)               begin m_run = 1; m_alt = 0; end
                else if (raw_bit == m_last) begin m_run++;   m_alt = 0; end
                else                       begin m_run = 1; m_alt++;   end
                m_have = 1; m_last = raw_bit;
            end
            if (ent_clk_edge) begin
                if (m_gap < 16) m_clive = 0;
                m_gap = 0;
            end else begin
                m_gap++;
                if (m_gap >= 16) m_clive = 1;
            end
            if (new_word) m_rdy = 1; else if (data_rd) m_rdy = 0;
            m_sflag = old_s || (m_sflag && !(stat_wr_en && !stat_wdata[6]));
            m_cflag = old_c || (m_cflag && !(stat_wr_en && !stat_wdata[5]));
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R6 ready",              {31'b0, stat_word[0]}, {31'b0, m_rdy});
        chk("R4 R5 clock status",    {31'b0, stat_word[1]}, {31'b0, m_clive});
        chk("R1 R2 R3 seed status",  {31'b0, stat_word[2]}, {31'b0, m_slive()});
        chk("R7 R8 clock flag",      {31'b0, stat_word[5]}, {31'b0, m_cflag});
        chk("R7 R8 seed flag",       {31'b0, stat_word[6]}, {31'b0, m_sflag});
        chk("R9 reserved bits",      stat_word & 32'hFFFF_FF98, 32'h0);
        chk("R10 irq",               {31'b0, irq},
            {31'b0, irq_en && (m_sflag || m_cflag)});
    endtask

    // one cycle: compare after the previous edge, then drive the next inputs
    task automatic step(input bit b, input bit v);
        @(negedge clk);
        compare();
        raw_bit = b;
        raw_vld = v;
        ent_clk_edge = (ep != 0) && (ecc % ep == 0);
        ecc++;
        new_word = 0; data_rd = 0; stat_wr_en = 0; stat_wdata = 0;
    endtask

    task automatic feed(input bit b, input int n);
        for (int i = 0; i < n; i++) step(b, 1'b1);
    endtask

    task automatic wr_status(input logic [31:0] d);
        step(raw_bit, 1'b0);
        stat_wr_en = 1; stat_wdata = d;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) @(negedge clk);
        rst = 0;
        // R11: reset state
        @(negedge clk);
        chk("R11 reset stat_word", stat_word, 32'h0);
        chk("R11 reset irq", {31'b0, irq}, 32'h0);
        irq_en = 1;

        // R1: long run of ones, broken by invalid cycles
        feed(1'b1, 40);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        feed(1'b1, 26);
        step(1'b1, 1'b0);
        // R3: pattern break clears the live status
        feed(1'b0, 1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        // R7: writing 1 has no effect, writing 0 clears
        wr_status(32'hFFFF_FFFF);
        wr_status(32'h0);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0);

        // R2: exactly 33 alternating bits (32 transitions) -> no error
        for (int i = 0; i < 33; i++) step(i[0], 1'b1);
        feed(1'b1, 3);
        // R2: 40 alternating bits, valid every other cycle
        for (int i = 0; i < 40; i++) begin
            step(i[0], 1'b1);
            step(1'b0, 1'b0);
        end
        // R8: clear while condition still active
        stat_wr_en = 1; stat_wdata = 32'h0;
        step(1'b1, 1'b1);
        stat_wr_en = 1; stat_wdata = 32'h0;
        feed(1'b1, 2);
        wr_status(32'h0);
        step(1'b0, 1'b0);

        // R1 boundary: exactly 64 identical bits -> no error
        feed(1'b0, 1);
        feed(1'b1, 64);
        feed(1'b0, 1);

        // R4: stop the entropy clock
        ep = 0;
        for (int i = 0; i < 25; i++) step(1'b0, 1'b0);
        // R5: late edge keeps error, timely edges clear it
        ep = 16; ecc = 0;
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
        wr_status(32'h0);
        // R4: period 17 is too slow, period 16 is fine
        ep = 17; ecc = 1;
        for (int i = 0; i < 60; i++) step(1'b0, 1'b0);
        ep = 16; ecc = 0;
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
        wr_status(32'hFFFF_FF9F);
        step(1'b0, 1'b0);

        // R6: ready set, read, collision, R10 enable gating
        new_word = 1; step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        data_rd = 1; step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        new_word = 1; data_rd = 1; step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        ep = 0;
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
        irq_en = 0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        irq_en = 1;
        step(1'b0, 1'b0);

        // R11: reset in the middle of activity
        rst = 1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        rst = 0;
        ep = 8;
        @(negedge clk);
        chk("R11 reset stat_word again", stat_word, 32'h0);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule